// File: doc/BRIEF.md
# Instruction Prefetch Queue with Bus Arbitration

This block keeps a small byte-wide instruction queue ahead of an execution stage. Code arrives from a bus-cycle interface as 16-bit words, while the execution stage takes one opcode byte per request from the head of the queue. The block holds its own fetch pointer, a code segment base plus an offset. The physical fetch address is the segment shifted left by four bits plus the offset, truncated to `OW+4` bits.

It decides on each idle bus clock whether to start a code fetch, hand the bus to a pending operand access from the execution stage, or leave the bus idle. Operand accesses win over code fetches. A code fetch that is already under way always runs to its acknowledge, and only then can an operand cycle start. On a taken branch the queue is emptied at once and the pointer is reloaded with the target offset. Data from a fetch that was in flight at the branch is thrown away. An odd target is handled with one high-byte-only fetch, so that every later fetch is word aligned. A wrapping counter records the clocks on which the bus was idle.

Top module: `prefetch_queue`

## Requirements
- R1: `count_o` is the number of queued bytes and never exceeds `DEPTH`. `empty_o` is high exactly when the count is 0, and `full_o` is high exactly when the count equals `DEPTH`.
- R2: On a clock where no bus cycle is active, a code fetch starts (`bus_req_o` and `bus_code_o` high from the next clock) only if `opr_req_i` is low, `branch_i` is low and at least two byte slots are free.
- R3: On a clock where no bus cycle is active and `opr_req_i` is high, an operand cycle starts (`opr_gnt_o` high from the next clock). A code fetch in progress stays active until `bus_ack_i`, and only after that can an operand cycle begin.
- R4: `byte_o` shows the oldest byte whenever `byte_vld_o` is high. A clock with `rd_req_i` high, a non-empty queue and `branch_i` low removes exactly that byte, so bytes leave in address order. For a word fetch, `bus_data_i[7:0]` is the byte at the even address and is queued before `bus_data_i[15:8]`.
- R5: `stall_o` is high when `rd_req_i` is high and the queue is empty. No byte is removed on such a clock.
- R6: While a code fetch is active, `bus_addr_o` equals `{seg_i,4'h0} + offset` modulo 2^(OW+4), using the values at the start of the fetch. After an acknowledged word fetch the offset advances by 2, modulo 2^OW.
- R7: When the offset is odd at the start of a fetch, `bus_hi_only_o` is high for that fetch. Only `bus_data_i[15:8]` is queued and the offset advances by 1.
- R8: A clock with `branch_i` high leaves the queue empty on the next clock and loads the offset with `target_i`. Any pop or queue write on that clock is dropped.
- R9: If a branch occurs while a code fetch is active and not yet acknowledged, the fetch continues to its `bus_ack_i`, and the data it returns is not queued and does not advance the offset.
- R10: `idle_cnt_o` increments, modulo 2^`IDLE_W`, on every clock where no bus cycle is active and none starts.
- R11: A pop and a fetch write on the same clock are both performed, and the count changes by the number written minus one.
- R12: During and just after reset the queue is empty, no bus cycle is active, `idle_cnt_o` is 0 and the offset equals `RST_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seg_i | input | OW | Code segment base |
| branch_i | input | 1 | Taken branch: flush and reload the pointer |
| target_i | input | OW | Branch target offset |
| rd_req_i | input | 1 | Execution stage requests one byte |
| byte_o | output | 8 | Head-of-queue byte |
| byte_vld_o | output | 1 | Head byte is valid |
| stall_o | output | 1 | Byte requested from an empty queue |
| opr_req_i | input | 1 | Execution stage wants an operand bus cycle |
| opr_gnt_o | output | 1 | Operand cycle owns the bus |
| bus_req_o | output | 1 | A bus cycle is active |
| bus_code_o | output | 1 | Active cycle is a code fetch |
| bus_hi_only_o | output | 1 | Code fetch takes only the high byte |
| bus_addr_o | output | OW+4 | Physical code fetch address |
| bus_ack_i | input | 1 | Bus cycle completes on this clock |
| bus_data_i | input | 16 | Fetched word |
| count_o | output | $clog2(DEPTH+1) | Queued byte count |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| idle_cnt_o | output | IDLE_W | Idle bus clock counter |

## Verification
The bench keeps `DEPTH` at 6 and `OW` at 16, and lowers `IDLE_W` to 6 so that the idle counter wraps after 64 idle clocks, well within a phase in which the queue is left full. `RST_OFF` is set to 0x0100 and a segment of 0xFFF0 is used, so that the 20-bit address sum wraps. A branch to offset 0xFFFF reaches both the odd-target single-byte fetch and the wrap of the offset. Acknowledge latencies vary from zero to three wait clocks, so branches and operand requests land both inside and between code fetches.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_CODE = 2'd1,
    BUS_OPER = 2'd2
  } bus_st_e;
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          pop_i,
  input  logic [1:0]    push_cnt_i,
  input  logic [7:0]    push_b0_i,
  input  logic [7:0]    push_b1_i,
  output logic [7:0]    head_o,
  output logic [CW-1:0] count_o
);
  logic [DEPTH-1:0][7:0] q_q, q_d;
  logic [CW-1:0]         cnt_q, cnt_mid, cnt_d;

  // entry 0 is the head; pop shifts, then writes land behind the survivors
  always_comb begin
    q_d     = q_q;
    cnt_mid = cnt_q;
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) q_d[i] = q_q[i+1];
      q_d[DEPTH-1] = '0;
      cnt_mid = cnt_q - CW'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push_cnt_i != 2'd0 && i == int'(cnt_mid))       q_d[i] = push_b0_i;
      if (push_cnt_i == 2'd2 && i == int'(cnt_mid) + 1)   q_d[i] = push_b1_i;
    end
    cnt_d = cnt_mid + CW'(push_cnt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end

  assign head_o  = q_q[0];
  assign count_o = cnt_q;
endmodule

// File: rtl/pfq_bus.sv
module pfq_bus
  import pfq_pkg::*;
#(
  parameter int          DEPTH   = 6,
  parameter int          CW      = $clog2(DEPTH + 1),
  parameter int          OW      = 16,
  parameter int          IDLE_W  = 16,
  parameter logic [OW-1:0] RST_OFF = '0,
  localparam int         AW      = OW + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OW-1:0]     seg_i,
  input  logic [OW-1:0]     target_i,
  input  logic              branch_i,
  input  logic              opr_req_i,
  input  logic              ack_i,
  input  logic [15:0]       data_i,
  input  logic [CW-1:0]     count_i,
  output logic              req_o,
  output logic              code_o,
  output logic              hi_only_o,
  output logic              opr_gnt_o,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        push_cnt_o,
  output logic [7:0]        push_b0_o,
  output logic [7:0]        push_b1_o,
  output logic [IDLE_W-1:0] idle_cnt_o
);
  bus_st_e           st_q, st_d;
  logic [OW-1:0]     off_q;
  logic [AW-1:0]     addr_q;
  logic              hi_q, stale_q;
  logic [IDLE_W-1:0] idle_q;
  logic              fetch_done, keep, start_op, start_code;

  assign fetch_done = (st_q == BUS_CODE) && ack_i;
  assign keep       = fetch_done && !stale_q && !branch_i;
  assign start_op   = (st_q == BUS_IDLE) && opr_req_i;
  assign start_code = (st_q == BUS_IDLE) && !opr_req_i && !branch_i &&
                      (count_i <= CW'(DEPTH - 2));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      BUS_IDLE: if (start_op) st_d = BUS_OPER;
                else if (start_code) st_d = BUS_CODE;
      default:  if (ack_i) st_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      off_q   <= RST_OFF;
      addr_q  <= '0;
      hi_q    <= 1'b0;
      stale_q <= 1'b0;
      idle_q  <= '0;
    end else begin
      st_q <= st_d;
      if (branch_i)  off_q <= target_i;
      else if (keep) off_q <= off_q + (hi_q ? OW'(1) : OW'(2));
      if (start_code) begin
        addr_q <= {seg_i, 4'h0} + {4'h0, off_q};
        hi_q   <= off_q[0];
      end
      // in-flight data becomes stale on a branch; cleared when that cycle ends
      if (fetch_done)                          stale_q <= 1'b0;
      else if (branch_i && st_q == BUS_CODE)   stale_q <= 1'b1;
      if (st_q == BUS_IDLE && !start_op && !start_code) idle_q <= idle_q + IDLE_W'(1);
    end
  end

  assign req_o      = (st_q != BUS_IDLE);
  assign code_o     = (st_q == BUS_CODE);
  assign opr_gnt_o  = (st_q == BUS_OPER);
  assign hi_only_o  = hi_q;
  assign addr_o     = addr_q;
  assign push_cnt_o = !keep ? 2'd0 : (hi_q ? 2'd1 : 2'd2);
  assign push_b0_o  = hi_q ? data_i[15:8] : data_i[7:0];
  assign push_b1_o  = data_i[15:8];
  assign idle_cnt_o = idle_q;
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int            DEPTH   = 6,
  parameter int            OW      = 16,
  parameter int            IDLE_W  = 16,
  parameter logic [OW-1:0] RST_OFF = '0,
  localparam int           CW      = $clog2(DEPTH + 1),
  localparam int           AW      = OW + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OW-1:0]     seg_i,
  input  logic              branch_i,
  input  logic [OW-1:0]     target_i,
  input  logic              rd_req_i,
  output logic [7:0]        byte_o,
  output logic              byte_vld_o,
  output logic              stall_o,
  input  logic              opr_req_i,
  output logic              opr_gnt_o,
  output logic              bus_req_o,
  output logic              bus_code_o,
  output logic              bus_hi_only_o,
  output logic [AW-1:0]     bus_addr_o,
  input  logic              bus_ack_i,
  input  logic [15:0]       bus_data_i,
  output logic [CW-1:0]     count_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [IDLE_W-1:0] idle_cnt_o
);
  logic [1:0] push_cnt;
  logic [7:0] push_b0, push_b1;
  logic       pop;

  assign empty_o    = (count_o == '0);
  assign full_o     = (count_o == CW'(DEPTH));
  assign byte_vld_o = !empty_o;
  assign stall_o    = rd_req_i && empty_o;
  assign pop        = rd_req_i && !empty_o && !branch_i;

  pfq_bus #(
    .DEPTH(DEPTH), .CW(CW), .OW(OW), .IDLE_W(IDLE_W), .RST_OFF(RST_OFF)
  ) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .seg_i      (seg_i),
    .target_i   (target_i),
    .branch_i   (branch_i),
    .opr_req_i  (opr_req_i),
    .ack_i      (bus_ack_i),
    .data_i     (bus_data_i),
    .count_i    (count_o),
    .req_o      (bus_req_o),
    .code_o     (bus_code_o),
    .hi_only_o  (bus_hi_only_o),
    .opr_gnt_o  (opr_gnt_o),
    .addr_o     (bus_addr_o),
    .push_cnt_o (push_cnt),
    .push_b0_o  (push_b0),
    .push_b1_o  (push_b1),
    .idle_cnt_o (idle_cnt_o)
  );

  pfq_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (branch_i),
    .pop_i      (pop),
    .push_cnt_i (push_cnt),
    .push_b0_i  (push_b0),
    .push_b1_i  (push_b1),
    .head_o     (byte_o),
    .count_o    (count_o)
  );
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
  parameter int DEPTH = 6,
  parameter int CW    = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          branch_i,
  input logic          opr_req_i,
  input logic          bus_ack_i,
  input logic          bus_req_o,
  input logic          bus_code_o,
  input logic          opr_gnt_o,
  input logic          stall_o,
  input logic          empty_o,
  input logic [CW-1:0] count_o
);
  // R1
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= DEPTH);

  // R2
  code_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_code_o) |-> $past(!opr_req_i && !branch_i && int'(count_o) <= DEPTH - 2));

  // R3
  fetch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_code_o && !bus_ack_i) |=> bus_code_o);

  // R3
  opr_pri_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_req_o && opr_req_i) |=> opr_gnt_o);

  // R5
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !branch_i) |=> count_o >= $past(count_o));

  // R8
  flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_i |=> empty_o);
endmodule

bind prefetch_queue pfq_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .branch_i   (branch_i),
  .opr_req_i  (opr_req_i),
  .bus_ack_i  (bus_ack_i),
  .bus_req_o  (bus_req_o),
  .bus_code_o (bus_code_o),
  .opr_gnt_o  (opr_gnt_o),
  .stall_o    (stall_o),
  .empty_o    (empty_o),
  .count_o    (count_o)
);

// File: tb/sim_prefetch_queue.sv
module sim_prefetch_queue;
  localparam int DEPTH = 6;
  localparam int IW    = 6;
  localparam int CW    = $clog2(DEPTH + 1);

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] seg_i = 16'h1234;
  logic        branch_i = 1'b0;
  logic [15:0] target_i = '0;
  logic        rd_req_i = 1'b0;
  logic        opr_req_i = 1'b0;
  logic        bus_ack_i = 1'b0;
  logic [15:0] bus_data_i = '0;
  logic [7:0]  byte_o;
  logic        byte_vld_o, stall_o, opr_gnt_o, bus_req_o, bus_code_o, bus_hi_only_o;
  logic [19:0] bus_addr_o;
  logic [CW-1:0] count_o;
  logic        empty_o, full_o;
  logic [IW-1:0] idle_cnt_o;

  always #4 clk = ~clk;

  prefetch_queue #(.DEPTH(DEPTH), .OW(16), .IDLE_W(IW), .RST_OFF(16'h0100)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .seg_i(seg_i), .branch_i(branch_i), .target_i(target_i),
    .rd_req_i(rd_req_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o), .stall_o(stall_o),
    .opr_req_i(opr_req_i), .opr_gnt_o(opr_gnt_o), .bus_req_o(bus_req_o),
    .bus_code_o(bus_code_o), .bus_hi_only_o(bus_hi_only_o), .bus_addr_o(bus_addr_o),
    .bus_ack_i(bus_ack_i), .bus_data_i(bus_data_i), .count_o(count_o),
    .empty_o(empty_o), .full_o(full_o), .idle_cnt_o(idle_cnt_o)
  );

  int nchk = 0, nerr = 0;
  bit finished = 0;

  function automatic logic [7:0] mem_f(logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'h5a;
  endfunction

  task automatic chk(string rq, string nm, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", rq, nm, act, exp, $time);
    end
  endtask

  // reference model: state 0 idle, 1 code fetch, 2 operand
  byte unsigned mq[$];
  int          m_st;
  logic [15:0] m_off;
  logic [19:0] m_addr;
  bit          m_hi, m_stale;
  int          m_idle;
  bit          ev_flush, ev_stale, ev_both;

  always @(posedge clk) begin
    bit done, keep, pop, so, sc;
    if (!rst_ni) begin
      mq.delete(); m_st = 0; m_off = 16'h0100; m_addr = '0; m_hi = 0; m_stale = 0;
      m_idle = 0; ev_flush = 0; ev_stale = 0; ev_both = 0;
    end else begin
      done = (m_st == 1) && bus_ack_i;
      keep = done && !m_stale && !branch_i;
      pop  = rd_req_i && mq.size() > 0 && !branch_i;
      so   = (m_st == 0) && opr_req_i;
      sc   = (m_st == 0) && !opr_req_i && !branch_i && mq.size() <= DEPTH - 2;
      ev_flush = branch_i; ev_stale = done && m_stale; ev_both = pop && keep;
      if (branch_i) mq.delete();
      else begin
        if (pop) void'(mq.pop_front());
        if (keep) begin
          mq.push_back(mem_f(m_addr));
          if (!m_hi) mq.push_back(mem_f(m_addr + 20'd1));
        end
      end
      if (done) m_stale = 0;
      else if (branch_i && m_st == 1) m_stale = 1;
      if (m_st == 0 && !so && !sc) m_idle = (m_idle + 1) % (1 << IW);
      if (sc) begin
        m_addr = {seg_i, 4'h0} + {4'h0, m_off};
        m_hi   = m_off[0];
      end
      if (branch_i) m_off = target_i;
      else if (keep) m_off = m_off + (m_hi ? 16'd1 : 16'd2);
      if (m_st == 0) m_st = so ? 2 : (sc ? 1 : 0);
      else if (bus_ack_i) m_st = 0;
    end
  end

  // compare every clock, mid-cycle
  always @(negedge clk) begin
    string tc;
    if (rst_ni && !finished) begin
      tc = ev_stale ? "R9" : ev_flush ? "R8" : ev_both ? "R11" : "R1";
      chk(tc, "count", int'(count_o), mq.size());
      chk("R1", "empty", int'(empty_o), int'(mq.size() == 0));
      chk("R1", "full", int'(full_o), int'(mq.size() == DEPTH));
      if (mq.size() > 0) chk("R4", "byte", int'(byte_o), int'(mq[0]));
      chk("R5", "stall", int'(stall_o), int'(rd_req_i && mq.size() == 0));
      chk("R2", "bus_req", int'(bus_req_o), int'(m_st != 0));
      chk("R2", "bus_code", int'(bus_code_o), int'(m_st == 1));
      chk("R3", "opr_gnt", int'(opr_gnt_o), int'(m_st == 2));
      if (m_st == 1) begin
        chk("R6", "addr", int'(bus_addr_o), int'(m_addr));
        chk("R7", "hi_only", int'(bus_hi_only_o), int'(m_hi));
      end
      chk("R10", "idle", int'(idle_cnt_o), m_idle);
    end
  end

  // bus responder
  int wt = 0;
  always begin
    @(negedge clk); #1;
    if (!rst_ni) begin
      bus_ack_i = 0; wt = 0;
    end else if (bus_ack_i) begin
      bus_ack_i = 0; wt = $urandom_range(0, 3);
    end else if (bus_req_o) begin
      if (wt == 0) begin
        bus_ack_i  = 1;
        bus_data_i = {mem_f(bus_addr_o | 20'd1), mem_f(bus_addr_o & ~20'd1)};
      end else wt--;
    end
  end

  task automatic cyc(int n, int p_rd, int p_op, int p_br);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      rd_req_i  = ($urandom % 100) < p_rd;
      opr_req_i = ($urandom % 100) < p_op;
      branch_i  = ($urandom % 100) < p_br;
      target_i  = 16'($urandom);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 during reset
    chk("R12", "rst_count", int'(count_o), 0);
    chk("R12", "rst_req", int'(bus_req_o), 0);
    chk("R12", "rst_idle", int'(idle_cnt_o), 0);
    #1 rst_ni = 1;
    @(negedge clk);
    // R12 first fetch uses RST_OFF: 0x12340 + 0x100
    chk("R12", "first_addr", int'(bus_addr_o), 'h12440);
    chk("R12", "first_empty", int'(empty_o), 1);
    cyc(200, 0, 0, 0);    // fill, then idle wrap (R10)
    cyc(400, 60, 0, 0);   // steady flow (R4, R11)
    cyc(400, 90, 15, 0);  // operand priority (R3)
    cyc(800, 70, 15, 3);  // branches mixed in (R8, R9)
    // R7: odd target
    @(negedge clk); #1; rd_req_i = 0; opr_req_i = 0; branch_i = 1; target_i = 16'h0233;
    @(negedge clk); #1; branch_i = 0;
    chk("R8", "flush_empty", int'(empty_o), 1);
    cyc(60, 50, 0, 0);
    // R9: branch while a fetch is pending
    for (int k = 0; k < 20; k++) begin
      do begin @(negedge clk); #1; rd_req_i = 0; branch_i = 0; end
      while (!(bus_code_o && !bus_ack_i));
      branch_i = 1; target_i = 16'h0400 + 16'(k);
      @(negedge clk); #1; branch_i = 0;
      cyc(10, 40, 0, 0);
    end
    // R6/R7: address and offset wrap
    @(negedge clk); #1; seg_i = 16'hFFF0; branch_i = 1; target_i = 16'hFFFF;
    @(negedge clk); #1; branch_i = 0;
    cyc(100, 40, 5, 0);
    cyc(400, 100, 0, 2);  // stall heavy (R5)
    cyc(20, 0, 0, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule